// File: doc/BRIEF.md
# Pulse-Swallow Programmable Divider

This block divides a fast input clock by a programmable integer ratio and emits one single-cycle pulse at the end of every division cycle. The pulse is the feedback edge that a phase detector compares against a reference. The ratio is built from three settings: a coarse modulus P, a main count N and a swallow count A. The total ratio is P×N+A. A dual-modulus prescaler divides by P+1 for the first A of its output ticks in a cycle and by P for the rest. The main counter ends the cycle after N prescaler ticks.

P is either 64 or 128 and is chosen with a one-bit select. The settings arrive on a parallel configuration port with a one-cycle load strobe. They are held in a pending register and take effect only at the next division-cycle boundary, so a cycle already in progress is never shortened or stretched. Settings that break the rules are repaired before use. A repaired setting raises an error flag that stays valid for the whole cycle that uses it.

Top module: `swallow_divider`

## Requirements
- R1: After reset `divPulse` and `cfgErr` are 0, and the block runs with A=0, N=16, P=64, which gives a pulse spacing of 1024 clocks.
- R2: With `cfgModSel`=1 (P=64) and a valid setting, consecutive pulses are exactly 64×N+A clocks apart.
- R3: With `cfgModSel`=0 (P=128) and a valid setting, consecutive pulses are exactly 128×N+A clocks apart.
- R4: `divPulse` is high for exactly one clock per division cycle.
- R5: A setting loaded with `cfgLoad` leaves the cycle in progress at its old length. It first governs the cycle that starts at the next pulse, and `cfgErr` changes only together with a pulse.
- R6: If several loads arrive within one division cycle, only the last one is applied at the boundary.
- R7: If A is not below the effective N, the block uses A=N−1 and sets `cfgErr` to 1 for the cycles that use that setting.
- R8: If N is below 16, N is forced to 16 and `cfgErr` is set. A is then compared against 16 under R7.
- R9: A later valid setting clears `cfgErr` at the boundary where it takes effect.
- R10: The edge settings A=0 and A=N−1 are valid (`cfgErr`=0) and give exactly P×N and P×N+N−1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast input clock being divided |
| rstN | input | 1 | Active-low asynchronous reset |
| cfgLoad | input | 1 | One-cycle strobe that captures the three settings below |
| cfgSwallow | input | 7 | Swallow count A |
| cfgMain | input | 11 | Main count N |
| cfgModSel | input | 1 | Modulus select: 1 gives P=64, 0 gives P=128 |
| divPulse | output | 1 | One-clock pulse at the end of each division cycle |
| cfgErr | output | 1 | The setting in use was repaired (R7/R8) |

## Verification
A wrong counter or prescaler state shows up as a wrong pulse spacing. An off-by-one in the swallow phase changes the spacing by exactly one clock, and a wrong modulus changes it by a multiple of N. Either error appears in the first full cycle after the faulty setting is applied. Applying settings at the wrong time shows up as a wrong length for the cycle that was running when the load arrived, or as `cfgErr` changing between pulses. Each check therefore compares one measured spacing with the ratio computed from the requirements.

// File: rtl/swdiv_pkg.sv
package swdiv_pkg;
  // Strobes from the control to the counter datapath
  typedef struct packed {
    logic reload;   // division cycle ends: load fresh counts
    logic step;     // prescaler tick inside the cycle
    logic swStep;   // this tick also consumes one swallow
  } divStrobe_t;
endpackage

// File: rtl/swdiv_ctrl.sv
module swdiv_ctrl
  import swdiv_pkg::*;
#(
  parameter int AW = 7,
  parameter int NW = 11,
  parameter int NMIN = 16,
  parameter int DEF_A = 0,
  parameter int DEF_N = 16,
  parameter bit DEF_SEL = 1'b1
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          cfgLoad,
  input  logic [AW-1:0] cfgSwallow,
  input  logic [NW-1:0] cfgMain,
  input  logic          cfgModSel,
  input  logic          prescZero,
  input  logic [AW-1:0] swRem,
  input  logic [NW-1:0] mainRem,
  output divStrobe_t    strobe,
  output logic [AW-1:0] loadA,
  output logic [NW-1:0] loadN,
  output logic          loadSel,
  output logic          curSel,
  output logic          cfgErr
);
  localparam logic [NW-1:0] N_FLOOR = NW'(NMIN);

  logic [NW-1:0] nFixed;
  logic [NW-1:0] aWide;
  logic [AW-1:0] aFixed;
  logic          errIn;

  logic [AW-1:0] pendA,  actA;
  logic [NW-1:0] pendN,  actN;
  logic          pendSel, actSel, pendErr, pendValid, errQ;
  logic          cycleEnd, nextErr;

  // Repair an incoming setting before it is stored
  always_comb begin
    nFixed = (cfgMain < N_FLOOR) ? N_FLOOR : cfgMain;
    aWide  = {{(NW-AW){1'b0}}, cfgSwallow};
    aFixed = (aWide >= nFixed) ? AW'(nFixed - 1'b1) : cfgSwallow;
    errIn  = (cfgMain < N_FLOOR) || (aWide >= nFixed);
  end

  assign cycleEnd = prescZero && (mainRem == NW'(1));

  always_comb begin
    loadA   = pendValid ? pendA   : actA;
    loadN   = pendValid ? pendN   : actN;
    loadSel = pendValid ? pendSel : actSel;
    nextErr = pendValid ? pendErr : errQ;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pendA     <= AW'(DEF_A);
      pendN     <= NW'(DEF_N);
      pendSel   <= DEF_SEL;
      pendErr   <= 1'b0;
      pendValid <= 1'b0;
      actA      <= AW'(DEF_A);
      actN      <= NW'(DEF_N);
      actSel    <= DEF_SEL;
      errQ      <= 1'b0;
    end else begin
      if (cycleEnd) begin
        actA   <= loadA;
        actN   <= loadN;
        actSel <= loadSel;
        errQ   <= nextErr;
      end
      if (cfgLoad) begin
        pendA   <= aFixed;
        pendN   <= nFixed;
        pendSel <= cfgModSel;
        pendErr <= errIn;
      end
      pendValid <= cfgLoad ? 1'b1 : (cycleEnd ? 1'b0 : pendValid);
    end
  end

  always_comb begin
    strobe.reload = cycleEnd;
    strobe.step   = prescZero && !cycleEnd;
    strobe.swStep = prescZero && !cycleEnd && (swRem != '0);
  end

  assign curSel = actSel;
  assign cfgErr = errQ;
endmodule

// File: rtl/swdiv_path.sv
module swdiv_path
  import swdiv_pkg::*;
#(
  parameter int AW = 7,
  parameter int NW = 11,
  parameter int PLOW = 64,
  parameter int PHIGH = 128,
  parameter int DEF_A = 0,
  parameter int DEF_N = 16,
  parameter bit DEF_SEL = 1'b1
) (
  input  logic          clk,
  input  logic          rstN,
  input  divStrobe_t    strobe,
  input  logic [AW-1:0] loadA,
  input  logic [NW-1:0] loadN,
  input  logic          loadSel,
  input  logic          curSel,
  output logic          prescZero,
  output logic [AW-1:0] swRem,
  output logic [NW-1:0] mainRem,
  output logic          divPulse
);
  localparam int PW = $clog2(PHIGH + 1);

  // Prescaler reload: P for a swallowing segment (P+1 clocks), P-1 otherwise
  function automatic logic [PW-1:0] segLoad(input logic sel, input logic swallowing);
    logic [PW-1:0] base;
    base = sel ? PW'(PLOW) : PW'(PHIGH);
    return swallowing ? base : base - 1'b1;
  endfunction

  logic [PW-1:0] prescCnt;
  logic [AW-1:0] swNext;
  logic          pulseQ;

  assign swNext = strobe.swStep ? swRem - 1'b1 : swRem;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      swRem    <= AW'(DEF_A);
      mainRem  <= NW'(DEF_N);
      prescCnt <= segLoad(DEF_SEL, DEF_A != 0);
      pulseQ   <= 1'b0;
    end else begin
      pulseQ <= strobe.reload;
      if (strobe.reload) begin
        swRem    <= loadA;
        mainRem  <= loadN;
        prescCnt <= segLoad(loadSel, loadA != '0);
      end else if (strobe.step) begin
        swRem    <= swNext;
        mainRem  <= mainRem - 1'b1;
        prescCnt <= segLoad(curSel, swNext != '0);
      end else begin
        prescCnt <= prescCnt - 1'b1;
      end
    end
  end

  assign prescZero = (prescCnt == '0);
  assign divPulse  = pulseQ;
endmodule

// File: rtl/swallow_divider.sv
module swallow_divider
  import swdiv_pkg::*;
#(
  parameter int AW = 7,
  parameter int NW = 11,
  parameter int PLOW = 64,
  parameter int PHIGH = 128,
  parameter int NMIN = 16,
  parameter int DEF_A = 0,
  parameter int DEF_N = 16,
  parameter bit DEF_SEL = 1'b1
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          cfgLoad,
  input  logic [AW-1:0] cfgSwallow,
  input  logic [NW-1:0] cfgMain,
  input  logic          cfgModSel,
  output logic          divPulse,
  output logic          cfgErr
);
  divStrobe_t    strobe;
  logic [AW-1:0] loadA, swRem;
  logic [NW-1:0] loadN, mainRem;
  logic          loadSel, curSel, prescZero;

  swdiv_ctrl #(
    .AW(AW), .NW(NW), .NMIN(NMIN),
    .DEF_A(DEF_A), .DEF_N(DEF_N), .DEF_SEL(DEF_SEL)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .cfgLoad(cfgLoad),
    .cfgSwallow(cfgSwallow), .cfgMain(cfgMain), .cfgModSel(cfgModSel),
    .prescZero(prescZero), .swRem(swRem), .mainRem(mainRem),
    .strobe(strobe), .loadA(loadA), .loadN(loadN), .loadSel(loadSel),
    .curSel(curSel), .cfgErr(cfgErr)
  );

  swdiv_path #(
    .AW(AW), .NW(NW), .PLOW(PLOW), .PHIGH(PHIGH),
    .DEF_A(DEF_A), .DEF_N(DEF_N), .DEF_SEL(DEF_SEL)
  ) u_path (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .loadA(loadA), .loadN(loadN), .loadSel(loadSel), .curSel(curSel),
    .prescZero(prescZero), .swRem(swRem), .mainRem(mainRem),
    .divPulse(divPulse)
  );
endmodule

// File: rtl/swdiv_chk.sv
module swdiv_chk #(
  parameter int AW = 7,
  parameter int NW = 11,
  parameter int PHIGH = 128
) (
  input logic          clk,
  input logic          rstN,
  input logic          divPulse,
  input logic          cfgErr,
  input logic [AW-1:0] swRem,
  input logic [NW-1:0] mainRem
);
  localparam int unsigned MAX_GAP = PHIGH * ((2 ** NW) - 1) + ((2 ** AW) - 1);

  logic [31:0] gap;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) gap <= '0;
    else       gap <= divPulse ? 32'd0 : gap + 32'd1;
  end

  AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    divPulse |=> !divPulse); // R4
  AST_ERR_AT_BOUNDARY: assert property (@(posedge clk) disable iff (!rstN)
    !divPulse |-> $stable(cfgErr)); // R5
  AST_SWALLOW_BELOW_MAIN: assert property (@(posedge clk) disable iff (!rstN)
    ({{(NW-AW){1'b0}}, swRem} < mainRem)); // R7
  AST_MAIN_NONZERO: assert property (@(posedge clk) disable iff (!rstN)
    (mainRem != '0)); // R2
  AST_GAP_BOUND: assert property (@(posedge clk) disable iff (!rstN)
    (gap <= MAX_GAP)); // R3
endmodule

bind swallow_divider swdiv_chk #(.AW(AW), .NW(NW), .PHIGH(PHIGH)) u_chk (
  .clk(clk), .rstN(rstN), .divPulse(divPulse), .cfgErr(cfgErr),
  .swRem(swRem), .mainRem(mainRem)
);

// File: tb/swallow_divider_tb.sv
`timescale 1ns/1ps
module swallow_divider_tb;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cfgLoad = 1'b0;
  logic [6:0]  cfgSwallow = '0;
  logic [10:0] cfgMain = '0;
  logic        cfgModSel = 1'b0;
  logic        divPulse, cfgErr;

  int checks = 0;
  int failures = 0;
  int cyc = 0, lastPulse = 0, lastInterval = 0, pulseCount = 0;
  logic prevPulse = 1'b0;
  int curRatio = 1024;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  swallow_divider u_dut (
    .clk(clk), .rstN(rstN), .cfgLoad(cfgLoad), .cfgSwallow(cfgSwallow),
    .cfgMain(cfgMain), .cfgModSel(cfgModSel), .divPulse(divPulse), .cfgErr(cfgErr)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Pulse monitor, sampled on the falling edge
  always @(negedge clk) begin
    if (!rstN) begin
      cyc = 0; lastPulse = 0; pulseCount = 0; prevPulse = 1'b0;
    end else begin
      cyc++;
      if (divPulse) begin
        if (pulseCount > 0) lastInterval = cyc - lastPulse;
        lastPulse = cyc;
        pulseCount++;
      end
      if (prevPulse) chk("R4 pulse width", int'(divPulse), 0);
      prevPulse = divPulse;
    end
  end

  function automatic int expRatio(input int a, input int n, input bit sel);
    int nE, aE;
    nE = (n < 16) ? 16 : n;
    aE = (a >= nE) ? nE - 1 : a;
    return (sel ? 64 : 128) * nE + aE;
  endfunction

  function automatic int expErr(input int a, input int n);
    int nE;
    nE = (n < 16) ? 16 : n;
    return ((n < 16) || (a >= nE)) ? 1 : 0;
  endfunction

  task automatic waitPulses(input int n);
    int target;
    target = pulseCount + n;
    while (pulseCount < target) begin
      @(negedge clk); #1;
    end
  endtask

  task automatic loadCfg(input int a, input int n, input bit sel);
    cfgSwallow = 7'(a); cfgMain = 11'(n); cfgModSel = sel; cfgLoad = 1'b1;
    @(negedge clk); #1;
    cfgLoad = 1'b0;
  endtask

  // Load mid-cycle, confirm the running cycle keeps its length, then measure
  task automatic applyCfg(input string req, input int a, input int n, input bit sel);
    waitPulses(1);
    loadCfg(a, n, sel);
    waitPulses(1);
    chk("R5 cycle in progress unchanged", lastInterval, curRatio);
    chk({req, " error flag"}, int'(cfgErr), expErr(a, n));
    waitPulses(1);
    curRatio = expRatio(a, n, sel);
    chk({req, " ratio"}, lastInterval, curRatio);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    chk("R1 reset pulse", int'(divPulse), 0);
    chk("R1 reset err", int'(cfgErr), 0);
    #1 rstN = 1'b1;
    waitPulses(2);
    chk("R1 default ratio", lastInterval, 1024);
    chk("R1 default err", int'(cfgErr), 0);

    applyCfg("R2", 5, 20, 1'b1);
    applyCfg("R3 R10 A=0", 0, 17, 1'b0);
    applyCfg("R10 A=N-1", 16, 17, 1'b1);
    applyCfg("R7", 30, 20, 1'b1);
    applyCfg("R9", 3, 18, 1'b1);
    applyCfg("R8", 2, 5, 1'b1);
    applyCfg("R9 after R8", 4, 16, 1'b0);

    // R6: two loads inside one cycle, the second must win
    waitPulses(1);
    loadCfg(1, 16, 1'b1);
    loadCfg(7, 19, 1'b1);
    waitPulses(1);
    chk("R6 running cycle", lastInterval, curRatio);
    waitPulses(1);
    curRatio = expRatio(7, 19, 1'b1);
    chk("R6 last load wins", lastInterval, curRatio);

    void'($urandom(32'd2024));
    for (int i = 0; i < 6; i++) begin
      int n, a;
      bit s;
      n = 16 + int'($urandom % 15);
      a = int'($urandom % (n + 3));
      s = 1'($urandom % 2);
      applyCfg(expErr(a, n) != 0 ? "R7 random" : (s ? "R2 random" : "R3 random"), a, n, s);
    end

    if (!finished) begin
      finished = 1'b1;
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      checks++;
      failures++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule